// File: doc/BRIEF.md
# Ring-of-pages DMA write engine

This block sits on the device side and streams incoming data words into a large host buffer built from scattered physical pages. Host memory holds a table of page start addresses. The engine walks this table as an endless ring. It reads one entry through a memory-read request/response port and fills that page with word writes on a write request port. When the page is full it moves to the next entry. After the last entry it returns to entry 0, so the driver never reprograms the engine during a session.

Every completed page raises a level interrupt and increments a completed-pages counter. Software frees pages by advancing a release index. The engine will not begin a page that software still owns. While it waits for a release, it holds the input stream off and reports a stall status bit.

Both data-carrying interfaces use valid/ready:
- A word moves on a cycle where both valid and ready are high.
- A write request holds its valid, address and data steady until it is accepted.
- The input stream sees ready low in four cases: while a table read is pending, while the single write register is occupied and not being drained, while the ring is full, and while the engine is disabled.

Control and status go through a plain register write strobe and a combinational read-back mux.

Top module: `ring_page_dma`

## Requirements
- R1: After reset, irq, s_ready, wr_valid and tab_req_valid are low, and every register reads 0.
- R2: The table entry for index n is fetched from the table base plus 4*n. The fetch request holds valid and address until it is accepted. Only one fetch is outstanding at a time. s_ready stays low from the request until the response is taken.
- R3: A page holds 2^P words, where P is the value of register 3. Word k of a page is written to the fetched entry address plus 4*k. Written data follows the input stream order with no loss or duplication.
- R4: After the last word of a page is written, the engine moves to the next entry. After entry count-1 it uses entry 0. The write index reads back as the entry now in use or awaited. A count of 0 is treated as 1.
- R5: The engine starts page k only when (k+1) mod count differs from the release index. While it is blocked, s_ready is low and status bit 1 reads 1.
- R6: irq rises on the cycle after the write handshake of a page's last word. It stays high until software writes 1 to status bit 0.
- R7: The completed-pages counter (register 6) increases by one for each completed page.
- R8: Writing 1 to control bit 0 while disabled starts the engine at entry 0, word offset 0 and write index 0. Writing 0 lets the write already in the write register finish. After that, no further fetch or write is issued, and s_ready stays low.
- R9: While wr_valid is high and wr_ready is low, wr_addr and wr_data stay stable and s_ready is low.
- R10: Register map, by word address:
  - 0: control, bit 0 enable.
  - 1: table base.
  - 2: entry count.
  - 3: page-size log2.
  - 4: release index.
  - 5: status, bit 0 irq pending (write 1 to clear), bit 1 stall.
  - 6: completed-pages counter.
  - 7: write index.

  Writable registers read back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| s_valid | input | 1 | Input stream word valid |
| s_ready | output | 1 | Input stream ready |
| s_data | input | DATA_W | Input stream word |
| tab_req_valid | output | 1 | Table read request valid |
| tab_req_ready | input | 1 | Table read request accepted |
| tab_req_addr | output | ADDR_W | Byte address of the table entry |
| tab_rsp_valid | input | 1 | Table read response valid |
| tab_rsp_data | input | ADDR_W | Page start address returned |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | DATA_W | Write data word |
| irq | output | 1 | Page-completed interrupt level |

## Verification
The assertions check the following on every cycle:
- fetch requests and write requests stay stable under back-pressure;
- a fetch never begins unless the ring had room;
- the entry index advances to the ring's successor on each page completion;
- the word offset stays inside the current page;
- irq sets on completion and falls only through a clear write;
- the completed-pages counter steps by one per page.

Only the bench's scenarios can show the rest. The exact address and data of every write, and wrap-around onto entry 0, are checked against arithmetic expectations. Stalling after the right number of pages for a given release index is also scenario-only. So are restart from entry 0 after a mid-page disable and clean stopping, both of which are checked across randomised ready and valid patterns and two page-size and count configurations.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT,
    ST_STREAM,
    ST_DRAIN
  } eng_state_t;

  localparam logic [2:0] RA_CTRL    = 3'd0;
  localparam logic [2:0] RA_TBASE   = 3'd1;
  localparam logic [2:0] RA_COUNT   = 3'd2;
  localparam logic [2:0] RA_PGLOG   = 3'd3;
  localparam logic [2:0] RA_RELEASE = 3'd4;
  localparam logic [2:0] RA_STATUS  = 3'd5;
  localparam logic [2:0] RA_DONE    = 3'd6;
  localparam logic [2:0] RA_WIDX    = 3'd7;

endpackage

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12,
  parameter int PGL_W  = 4,
  parameter int CNT_W  = 32,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              page_done,
  input  logic              stall,
  input  logic [IDX_W-1:0]  wr_idx,
  output logic              en,
  output logic              start,
  output logic [ADDR_W-1:0] tbase,
  output logic [IDX_W-1:0]  count,
  output logic [PGL_W-1:0]  pglog,
  output logic [IDX_W-1:0]  release_idx,
  output logic              irq
);

  logic [CNT_W-1:0] done_cnt;
  logic             clr_irq;

  assign start   = reg_we && (reg_addr == RA_CTRL) && reg_wdata[0] && !en;
  assign clr_irq = reg_we && (reg_addr == RA_STATUS) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en          <= 1'b0;
      tbase       <= '0;
      count       <= '0;
      pglog       <= '0;
      release_idx <= '0;
      irq         <= 1'b0;
      done_cnt    <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RA_CTRL:    en          <= reg_wdata[0];
          RA_TBASE:   tbase       <= reg_wdata[ADDR_W-1:0];
          RA_COUNT:   count       <= reg_wdata[IDX_W-1:0];
          RA_PGLOG:   pglog       <= reg_wdata[PGL_W-1:0];
          RA_RELEASE: release_idx <= reg_wdata[IDX_W-1:0];
          default: ;
        endcase
      end
      if (page_done) begin
        irq      <= 1'b1;
        done_cnt <= done_cnt + 1'b1;
      end else if (clr_irq) begin
        irq <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:    reg_rdata = REG_W'(en);
      RA_TBASE:   reg_rdata = REG_W'(tbase);
      RA_COUNT:   reg_rdata = REG_W'(count);
      RA_PGLOG:   reg_rdata = REG_W'(pglog);
      RA_RELEASE: reg_rdata = REG_W'(release_idx);
      RA_STATUS:  reg_rdata = REG_W'({stall, irq});
      RA_DONE:    reg_rdata = REG_W'(done_cnt);
      default:    reg_rdata = REG_W'(wr_idx);
    endcase
  end

  // R6: completion sets the interrupt level
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> irq);

  // R6: the level falls only through a clear write
  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_irq));

  // R7: one count per completed page
  p_done_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> done_cnt == $past(done_cnt) + 1'b1);

endmodule

// File: rtl/ring_dma_ring.sv
module ring_dma_ring #(
  parameter int IDX_W = 12
) (
  input  logic [IDX_W-1:0] count,
  input  logic [IDX_W-1:0] release_idx,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] idx_next,
  output logic             full
);

  logic [IDX_W:0] cnt_eff;
  logic [IDX_W:0] inc;

  assign cnt_eff  = (count == '0) ? (IDX_W+1)'(1) : {1'b0, count};
  assign inc      = {1'b0, idx} + 1'b1;
  assign idx_next = (inc >= cnt_eff) ? '0 : inc[IDX_W-1:0];
  assign full     = (idx_next == release_idx);

endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 12,
  parameter int PG_LOG2_MAX = 12,
  parameter int PGL_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [ADDR_W-1:0] tbase,
  input  logic [PGL_W-1:0]  pglog_cfg,
  input  logic              full,
  input  logic [IDX_W-1:0]  idx_next,
  output logic [IDX_W-1:0]  entry_idx,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              tab_req_valid,
  input  logic              tab_req_ready,
  output logic [ADDR_W-1:0] tab_req_addr,
  input  logic              tab_rsp_valid,
  input  logic [ADDR_W-1:0] tab_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              page_done,
  output logic              stall
);

  localparam int OFF_W = PG_LOG2_MAX;

  eng_state_t        state;
  logic [ADDR_W-1:0] pg_base;
  logic [PGL_W-1:0]  pg_cur;
  logic [PGL_W-1:0]  pg_eff;
  logic [OFF_W-1:0]  offset;
  logic [OFF_W-1:0]  last_off;
  logic              last_pending;
  logic              wr_free;
  logic              accept;

  assign pg_eff   = (pglog_cfg > PGL_W'(PG_LOG2_MAX)) ? PGL_W'(PG_LOG2_MAX) : pglog_cfg;
  assign last_off = OFF_W'((32'd1 << pg_cur) - 32'd1);

  assign wr_free       = !wr_valid || wr_ready;
  assign s_ready       = en && (state == ST_STREAM) && wr_free;
  assign accept        = s_valid && s_ready;
  assign tab_req_valid = (state == ST_REQ);
  assign tab_req_addr  = tbase + ADDR_W'({entry_idx, 2'b00});
  assign page_done     = wr_valid && wr_ready && last_pending;
  assign stall         = en && (state == ST_CHECK) && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      entry_idx    <= '0;
      pg_base      <= '0;
      pg_cur       <= '0;
      offset       <= '0;
      last_pending <= 1'b0;
      wr_valid     <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
    end else begin
      if (wr_valid && wr_ready) begin
        wr_valid     <= 1'b0;
        last_pending <= 1'b0;
      end
      if (page_done) entry_idx <= idx_next;

      if (start) begin
        state     <= ST_CHECK;
        entry_idx <= '0;
        offset    <= '0;
      end else if (!en) begin
        case (state)
          ST_IDLE: ;
          ST_REQ:  if (tab_req_ready) state <= ST_WAIT;
          ST_WAIT: if (tab_rsp_valid) state <= ST_IDLE;
          default: if (wr_free) state <= ST_IDLE;
        endcase
      end else begin
        case (state)
          ST_CHECK: if (!full) state <= ST_REQ;
          ST_REQ:   if (tab_req_ready) state <= ST_WAIT;
          ST_WAIT: begin
            if (tab_rsp_valid) begin
              pg_base <= tab_rsp_data;
              pg_cur  <= pg_eff;
              offset  <= '0;
              state   <= ST_STREAM;
            end
          end
          ST_STREAM: begin
            if (accept) begin
              wr_valid <= 1'b1;
              wr_addr  <= pg_base + ADDR_W'({offset, 2'b00});
              wr_data  <= s_data;
              if (offset == last_off) begin
                last_pending <= 1'b1;
                state        <= ST_DRAIN;
              end else begin
                offset <= offset + 1'b1;
              end
            end
          end
          ST_DRAIN: if (page_done) state <= ST_CHECK;
          default: ;
        endcase
      end
    end
  end

  // R2: a pending table request keeps valid and address
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tab_req_valid && !tab_req_ready |=> tab_req_valid && $stable(tab_req_addr));

  // R9: a pending write keeps address and data
  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R5: a fetch starts only after the ring showed room
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ) && ($past(state) == ST_CHECK) |-> $past(!full));

  // R4: page completion moves to the ring successor
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    page_done && !start |=> entry_idx == $past(idx_next));

  // R3: the word offset stays inside the page
  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STREAM) |-> offset <= last_off);

  // R8: no new fetch begins while disabled
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !start |=> !tab_req_valid || $past(tab_req_valid));

endmodule

// File: rtl/ring_page_dma.sv
module ring_page_dma #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 12,
  parameter int PG_LOG2_MAX = 12,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              tab_req_valid,
  input  logic              tab_req_ready,
  output logic [ADDR_W-1:0] tab_req_addr,
  input  logic              tab_rsp_valid,
  input  logic [ADDR_W-1:0] tab_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              irq
);

  localparam int PGL_W = $clog2(PG_LOG2_MAX + 1);

  logic              en;
  logic              start;
  logic [ADDR_W-1:0] tbase;
  logic [IDX_W-1:0]  count;
  logic [PGL_W-1:0]  pglog;
  logic [IDX_W-1:0]  release_idx;
  logic [IDX_W-1:0]  entry_idx;
  logic [IDX_W-1:0]  idx_next;
  logic              full;
  logic              page_done;
  logic              stall;

  ring_dma_regs #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PGL_W(PGL_W), .CNT_W(CNT_W), .REG_W(32)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .page_done(page_done), .stall(stall), .wr_idx(entry_idx),
    .en(en), .start(start), .tbase(tbase), .count(count), .pglog(pglog),
    .release_idx(release_idx), .irq(irq)
  );

  ring_dma_ring #(.IDX_W(IDX_W)) u_ring (
    .count(count), .release_idx(release_idx), .idx(entry_idx),
    .idx_next(idx_next), .full(full)
  );

  ring_dma_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .PG_LOG2_MAX(PG_LOG2_MAX), .PGL_W(PGL_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .tbase(tbase),
    .pglog_cfg(pglog), .full(full), .idx_next(idx_next), .entry_idx(entry_idx),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .tab_req_valid(tab_req_valid), .tab_req_ready(tab_req_ready),
    .tab_req_addr(tab_req_addr), .tab_rsp_valid(tab_rsp_valid),
    .tab_rsp_data(tab_rsp_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .page_done(page_done), .stall(stall)
  );

endmodule

// File: tb/tb_ring_page_dma.sv
module tb_ring_page_dma;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        tab_req_valid;
  logic        tab_req_ready = 1'b0;
  logic [31:0] tab_req_addr;
  logic        tab_rsp_valid = 1'b0;
  logic [31:0] tab_rsp_data = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic        irq;

  ring_page_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .tab_req_valid(tab_req_valid),
    .tab_req_ready(tab_req_ready), .tab_req_addr(tab_req_addr),
    .tab_rsp_valid(tab_rsp_valid), .tab_rsp_data(tab_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq)
  );

  always #2 clk = ~clk;

  localparam logic [31:0] TBASE = 32'h0000_4000;

  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  int          cfg_cnt = 4;
  int          cfg_log = 2;
  int          exp_w = 0;
  int          exp_f = 0;
  int          tot_w = 0;
  int          src_idx = 0;
  bit          src_en = 0;
  bit          run = 0;
  bit          rsp_pend = 0;
  logic [31:0] rsp_val = '0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] ent(int n);
    return 32'h8000_0000 + (32'(n) << 16);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // stream, table and write-port models
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready      = run && (lfsr[0] | lfsr[3] | lfsr[9]);
    tab_req_ready = run && (lfsr[2] | lfsr[7]);
    s_valid       = src_en && (lfsr[5] | lfsr[11]);
    s_data        = 32'(src_idx);
    tab_rsp_valid = rsp_pend;
    tab_rsp_data  = rsp_val;
    rsp_pend      = 0;
    #1;
    if (tab_req_valid || tab_rsp_valid)
      chk(!s_ready, "R2", "s_ready during fetch", s_ready, 0);
    if (wr_valid && !wr_ready)
      chk(!s_ready, "R9", "s_ready while write held", s_ready, 0);
    if (tab_req_valid && tab_req_ready) begin
      chk(tab_req_addr == TBASE + 32'(4 * (exp_f % cfg_cnt)), "R2", "fetch addr",
          tab_req_addr, TBASE + 32'(4 * (exp_f % cfg_cnt)));
      rsp_val  = ent(exp_f % cfg_cnt);
      rsp_pend = 1;
      exp_f++;
    end
    if (wr_valid && wr_ready) begin
      automatic int pg = exp_w >> cfg_log;
      automatic int k  = exp_w & ((1 << cfg_log) - 1);
      automatic logic [31:0] ea = ent(pg % cfg_cnt) + 32'(4 * k);
      chk(wr_addr == ea, "R3", "write addr", wr_addr, ea);
      chk(wr_data == 32'(tot_w), "R3", "write data", wr_data, tot_w);
      exp_w++;
      tot_w++;
    end
    if (s_valid && s_ready) src_idx++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int          d0;
    int          w1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!irq && !s_ready && !wr_valid && !tab_req_valid, "R1", "outputs after reset",
        {irq, s_ready, wr_valid, tab_req_valid}, 0);
    for (int a = 0; a < 8; a++) begin
      rreg(3'(a), v);
      chk(v == 0, "R1", "register reset value", v, 0);
    end

    // session 1: 4 entries, 4-word pages, release 0
    run = 1;
    src_en = 1;
    wreg(3'd1, TBASE);
    wreg(3'd2, 32'd4);
    wreg(3'd3, 32'd2);
    wreg(3'd4, 32'd0);
    rreg(3'd1, v);
    chk(v == TBASE, "R10", "table base readback", v, TBASE);
    rreg(3'd2, v);
    chk(v == 4, "R10", "count readback", v, 4);
    cfg_cnt = 4; cfg_log = 2; exp_w = 0; exp_f = 0;
    wreg(3'd0, 32'd1);
    repeat (400) @(negedge clk);
    chk(exp_w == 12, "R5", "words before stall", exp_w, 12);
    chk(!s_ready, "R5", "s_ready while stalled", s_ready, 0);
    rreg(3'd5, v);
    chk(v[1] == 1'b1, "R5", "stall bit", v[1], 1);
    chk(irq == 1'b1, "R6", "irq after pages", irq, 1);
    rreg(3'd6, v);
    chk(v == 3, "R7", "done count", v, 3);
    rreg(3'd7, v);
    chk(v == 3, "R4", "write index at stall", v, 3);
    wreg(3'd5, 32'd1);
    #1;
    chk(irq == 1'b0, "R6", "irq after clear", irq, 0);
    repeat (20) @(negedge clk);
    chk(irq == 1'b0, "R6", "irq stays clear without page", irq, 0);

    wreg(3'd4, 32'd1);
    repeat (400) @(negedge clk);
    chk(exp_w == 16, "R5", "words after release 1", exp_w, 16);
    chk(irq == 1'b1, "R6", "irq after next page", irq, 1);
    rreg(3'd6, v);
    chk(v == 4, "R7", "done count", v, 4);
    rreg(3'd7, v);
    chk(v == 0, "R4", "write index wrapped", v, 0);

    wreg(3'd4, 32'd3);
    repeat (500) @(negedge clk);
    chk(exp_w == 24, "R4", "words after wrap", exp_w, 24);
    rreg(3'd6, v);
    chk(v == 6, "R7", "done count", v, 6);
    rreg(3'd7, v);
    chk(v == 2, "R4", "write index after wrap", v, 2);
    rreg(3'd5, v);
    chk(v[1] == 1'b1, "R5", "stall bit again", v[1], 1);

    // session 2: 3 entries, 8-word pages, disable mid-page
    wreg(3'd0, 32'd0);
    repeat (10) @(negedge clk);
    wreg(3'd2, 32'd3);
    wreg(3'd3, 32'd3);
    wreg(3'd4, 32'd0);
    cfg_cnt = 3; cfg_log = 3; exp_w = 0; exp_f = 0;
    wreg(3'd0, 32'd1);
    while (exp_w < 5) @(negedge clk);
    wreg(3'd0, 32'd0);
    repeat (50) @(negedge clk);
    w1 = exp_w;
    #1;
    chk(!s_ready && !wr_valid, "R8", "stopped after disable", {s_ready, wr_valid}, 0);
    chk(w1 < 16, "R8", "stopped before ring limit", w1, 15);
    repeat (100) @(negedge clk);
    chk(exp_w == w1, "R8", "no writes while disabled", exp_w, w1);
    rreg(3'd6, v);
    d0 = int'(v);

    // restart must begin at entry 0, offset 0
    exp_w = 0; exp_f = 0;
    wreg(3'd0, 32'd1);
    repeat (600) @(negedge clk);
    chk(exp_w == 16, "R8", "words after restart", exp_w, 16);
    rreg(3'd6, v);
    chk(int'(v) == d0 + 2, "R7", "done count after restart", v, d0 + 2);
    rreg(3'd7, v);
    chk(v == 2, "R8", "write index after restart", v, 2);
    rreg(3'd5, v);
    chk(v[1] == 1'b1, "R5", "stall bit count 3", v[1], 1);
    rreg(3'd3, v);
    chk(v == 3, "R10", "page log2 readback", v, 3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule